// File: doc/BRIEF.md
# Split 16-bit Timer/Counter with Capture

This block is a sixteen-bit counting unit that can also work as two eight-bit halves. A two-bit configuration value selects how the counter is split and what drives it. The first choice is two free-running eight-bit timers, each with its own prescaler. The second is an eight-bit timer in the low half beside an eight-bit event counter in the high half. The third is one sixteen-bit timer behind the low prescaler. The fourth is one sixteen-bit event counter with no prescaler in its path.

Each half compares its count with a programmable match value. When a counting step arrives while the count equals the match value, the half returns to zero and raises a sticky interrupt flag. In the sixteen-bit configurations the low half carries into the high half, and only the combined sixteen-bit match clears the counter.

Two capture inputs copy the running count into a capture register. In the split configurations each input covers its own half. In the sixteen-bit configurations either input copies both halves in the same clock. The event input and both capture inputs are asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector before it is used.

Top module: `tmr_split16`

## Requirements
- R1: While reset is asserted, `count`, `capture`, `irq_lo` and `irq_hi` are all zero.
- R2: In configuration 0 each half is a timer. A prescaler value P gives one step every P+1 clocks. A step taken while the half equals its match value clears the half to 0 and sets that half's flag; any other step adds one.
- R3: In configuration 1 the low half is a timer as in R2. The high half steps once for each rising edge of `evt_in` and wraps to 0 at its match value.
- R4: In configuration 2 the sixteen bits step at the low prescaler rate. The high byte increments on the low byte's carry. A step at the full match value {match_hi, match_lo} clears all sixteen bits and sets `irq_hi`. `irq_lo` is never set in configurations 2 and 3.
- R5: In configuration 3 the sixteen bits step once per rising edge of `evt_in`, with carry and full-match clear as in R4. Input pulses one clock high and one clock low are all counted.
- R6: `evt_in` has no effect on `count` in configurations 0 and 2.
- R7: In configurations 0 and 1, `cap_lo_in` copies only the low half into `capture[7:0]` and `cap_hi_in` copies only the high half into `capture[15:8]`. The other capture byte keeps its value.
- R8: In configurations 2 and 3, a rising edge on either capture input copies all sixteen count bits into `capture`.
- R9: If a capture input is first high before clock edge a, the value stored is the count held just after edge a+1.
- R10: The write port decodes `wr_sel` as follows: 0 = configuration from `wr_data[1:0]`, 1 = low match, 2 = high match, 3 = low prescaler, 4 = high prescaler, 5 = flag clear (bit 0 clears the low flag, bit 1 clears the high flag). A configuration write zeroes both halves and both prescalers.
- R11: A flag stays set until a flag-clear write. A set and a clear in the same clock leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R10) |
| wr_data | input | 8 | Write data |
| evt_in | input | 1 | Asynchronous event input |
| cap_lo_in | input | 1 | Asynchronous low-half capture input |
| cap_hi_in | input | 1 | Asynchronous high-half capture input |
| count | output | 16 | Running count, high half in bits 15:8 |
| capture | output | 16 | Capture register, high half in bits 15:8 |
| irq_lo | output | 1 | Low-half match flag |
| irq_hi | output | 1 | High-half or sixteen-bit match flag |

## Verification
The assertions assume that the event and capture inputs change at most once per clock and stay at each level for at least one full clock, so that every rising edge reaches the edge detector. They also assume that register writes are single-cycle strobes. The bench drives every asynchronous input on the falling clock edge and holds each level for one or three whole cycles. It writes match and prescaler values before the configuration write that restarts the counter, so the expected counts follow from the number of clocks or pulses since that restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL    = 2'd0,
        MODE_TMR_EVT = 2'd1,
        MODE_TMR16   = 2'd2,
        MODE_EVT16   = 2'd3
    } tmr_mode_e;

    localparam logic [2:0] SEL_MODE     = 3'd0;
    localparam logic [2:0] SEL_MATCH_LO = 3'd1;
    localparam logic [2:0] SEL_MATCH_HI = 3'd2;
    localparam logic [2:0] SEL_PRE_LO   = 3'd3;
    localparam logic [2:0] SEL_PRE_HI   = 3'd4;
    localparam logic [2:0] SEL_CLR      = 3'd5;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    // Bits 0..STAGES-1 form the synchronizer; bit STAGES holds the previous value.
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign pulse = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = tick ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_split16.sv
module tmr_split16
    import tmr_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [HALF_W-1:0]     wr_data,
    input  logic                  evt_in,
    input  logic                  cap_lo_in,
    input  logic                  cap_hi_in,
    output logic [2*HALF_W-1:0]   count,
    output logic [2*HALF_W-1:0]   capture,
    output logic                  irq_lo,
    output logic                  irq_hi
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int N_IN   = 3;
    localparam int N_PRE  = 2;

    typedef struct packed {
        tmr_mode_e         mode;
        logic [HALF_W-1:0] match_lo;
        logic [HALF_W-1:0] match_hi;
        logic [PRE_W-1:0]  pre_lo;
        logic [PRE_W-1:0]  pre_hi;
        logic [HALF_W-1:0] cnt_lo;
        logic [HALF_W-1:0] cnt_hi;
        logic [HALF_W-1:0] cap_lo;
        logic [HALF_W-1:0] cap_hi;
        logic              flag_lo;
        logic              flag_hi;
    } state_t;

    localparam state_t RST_VAL = '{MODE_DUAL, '1, '1, '0, '0, '0, '0, '0, '0, 1'b0, 1'b0};

    state_t s_d, s_q;

    // Input synchronizers: bit 0 event, bit 1 low capture, bit 2 high capture
    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] in_pls;
    assign raw_in = {cap_hi_in, cap_lo_in, evt_in};

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[i]),
            .pulse (in_pls[i])
        );
    end

    logic evt_pls, cap_lo_pls, cap_hi_pls;
    assign evt_pls    = in_pls[0];
    assign cap_lo_pls = in_pls[1];
    assign cap_hi_pls = in_pls[2];

    // Prescalers: index 0 drives the low half, index 1 the high half
    logic             mode_wr;
    logic [N_PRE-1:0] pre_en;
    logic [N_PRE-1:0] pre_tick;
    logic [PRE_W-1:0] pre_lim [N_PRE];

    assign mode_wr    = wr_en && (wr_sel == SEL_MODE);
    assign pre_en[0]  = (s_q.mode != MODE_EVT16);
    assign pre_en[1]  = (s_q.mode == MODE_DUAL);
    assign pre_lim[0] = s_q.pre_lo;
    assign pre_lim[1] = s_q.pre_hi;

    for (genvar p = 0; p < N_PRE; p++) begin : g_pre
        tmr_prescale #(.W(PRE_W)) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (mode_wr),
            .en    (pre_en[p]),
            .limit (pre_lim[p]),
            .tick  (pre_tick[p])
        );
    end

    // Step sources per configuration
    logic              wide;
    logic              lo_step;
    logic              hi_step;
    logic [FULL_W-1:0] full_cnt;
    logic [FULL_W-1:0] full_match;
    tmr_mode_e         cur_mode;

    assign cur_mode   = s_q.mode;
    assign wide       = (s_q.mode == MODE_TMR16) || (s_q.mode == MODE_EVT16);
    assign lo_step    = (s_q.mode == MODE_EVT16) ? evt_pls : pre_tick[0];
    assign hi_step    = (s_q.mode == MODE_DUAL) ? pre_tick[1] : evt_pls;
    assign full_cnt   = {s_q.cnt_hi, s_q.cnt_lo};
    assign full_match = {s_q.match_hi, s_q.match_lo};

    always_comb begin
        s_d = s_q;

        // Flag clear first, so a set in the same cycle wins
        if (wr_en && wr_sel == SEL_CLR) begin
            if (wr_data[0]) s_d.flag_lo = 1'b0;
            if (wr_data[1]) s_d.flag_hi = 1'b0;
        end

        // Counting
        if (wide) begin
            if (lo_step) begin
                if (full_cnt == full_match) begin
                    s_d.cnt_lo  = '0;
                    s_d.cnt_hi  = '0;
                    s_d.flag_hi = 1'b1;
                end else begin
                    {s_d.cnt_hi, s_d.cnt_lo} = full_cnt + FULL_W'(1);
                end
            end
        end else begin
            if (lo_step) begin
                if (s_q.cnt_lo == s_q.match_lo) begin
                    s_d.cnt_lo  = '0;
                    s_d.flag_lo = 1'b1;
                end else begin
                    s_d.cnt_lo = s_q.cnt_lo + HALF_W'(1);
                end
            end
            if (hi_step) begin
                if (s_q.cnt_hi == s_q.match_hi) begin
                    s_d.cnt_hi  = '0;
                    s_d.flag_hi = 1'b1;
                end else begin
                    s_d.cnt_hi = s_q.cnt_hi + HALF_W'(1);
                end
            end
        end

        // Capture
        if (wide) begin
            if (cap_lo_pls || cap_hi_pls) begin
                s_d.cap_lo = s_q.cnt_lo;
                s_d.cap_hi = s_q.cnt_hi;
            end
        end else begin
            if (cap_lo_pls) s_d.cap_lo = s_q.cnt_lo;
            if (cap_hi_pls) s_d.cap_hi = s_q.cnt_hi;
        end

        // Register writes; a configuration write restarts the counter
        if (wr_en) begin
            unique case (wr_sel)
                SEL_MODE: begin
                    s_d.mode   = tmr_mode_e'(wr_data[1:0]);
                    s_d.cnt_lo = '0;
                    s_d.cnt_hi = '0;
                end
                SEL_MATCH_LO: s_d.match_lo = wr_data;
                SEL_MATCH_HI: s_d.match_hi = wr_data;
                SEL_PRE_LO:   s_d.pre_lo   = wr_data[PRE_W-1:0];
                SEL_PRE_HI:   s_d.pre_hi   = wr_data[PRE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= s_d;
    end

    assign count   = full_cnt;
    assign capture = {s_q.cap_hi, s_q.cap_lo};
    assign irq_lo  = s_q.flag_lo;
    assign irq_hi  = s_q.flag_hi;
endmodule

// File: rtl/tmr_split16_chk.sv
module tmr_split16_chk
    import tmr_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_sel,
    input logic                clr_bit,
    input logic [2*HALF_W-1:0] count,
    input logic [2*HALF_W-1:0] capture,
    input logic                irq_lo,
    input logic                evt_pls,
    input logic                cap_lo_pls,
    input logic                cap_hi_pls,
    input logic                lo_tick,
    input tmr_mode_e           cur_mode
);
    logic mode_wr;
    assign mode_wr = wr_en && (wr_sel == SEL_MODE);

    p_mode_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> count == '0);

    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo && !(wr_en && wr_sel == SEL_CLR && clr_bit) |=> irq_lo);

    // R7 / R8: capture only moves after a synchronized capture pulse
    p_cap_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(capture) |-> $past(cap_lo_pls || cap_hi_pls));

    p_evt_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode == MODE_EVT16 && !evt_pls && !mode_wr |=> $stable(count));

    p_lo_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode != MODE_EVT16 && !lo_tick && !mode_wr
        |=> count[HALF_W-1:0] == $past(count[HALF_W-1:0]));

    p_no_lo_flag_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cur_mode[1]) |-> !$rose(irq_lo));
endmodule

bind tmr_split16 tmr_split16_chk #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .clr_bit    (wr_data[0]),
    .count      (count),
    .capture    (capture),
    .irq_lo     (irq_lo),
    .evt_pls    (evt_pls),
    .cap_lo_pls (cap_lo_pls),
    .cap_hi_pls (cap_hi_pls),
    .lo_tick    (pre_tick[0]),
    .cur_mode   (cur_mode)
);

// File: tb/tmr_split16_test.sv
module tmr_split16_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        evt_in = 1'b0;
    logic        cap_lo_in = 1'b0;
    logic        cap_hi_in = 1'b0;
    logic [15:0] count;
    logic [15:0] capture;
    logic        irq_lo;
    logic        irq_hi;

    int cyc = 0;
    int cyc0 = 0;
    int n_chk = 0;
    int n_bad = 0;

    tmr_split16 uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .evt_in(evt_in), .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
        .count(count), .capture(capture), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Write one register; a configuration write records the restart edge.
    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        #1;
        if (sel == 3'd0) cyc0 = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // which: 0 event, 1 low capture, 2 high capture
    task automatic pulse_in(input int which, input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (which)
                0: evt_in = 1'b1;
                1: cap_lo_in = 1'b1;
                default: cap_hi_in = 1'b1;
            endcase
            repeat (hi) @(negedge clk);
            evt_in = 1'b0; cap_lo_in = 1'b0; cap_hi_in = 1'b0;
            repeat (lo - 1) @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        int c;
        repeat (3) @(negedge clk);
        check("R1 count", int'(count), 0);
        check("R1 capture", int'(capture), 0);
        check("R1 flags", int'({irq_hi, irq_lo}), 0);
        rst_n = 1'b1;

        // Configuration 0: low P=2 M=9, high P=0 M=4; events applied too
        wr(3'd1, 8'd9); wr(3'd2, 8'd4); wr(3'd3, 8'd2); wr(3'd4, 8'd0);
        wr(3'd0, 8'd0);
        check("R10 count zero after configuration write", int'(count), 0);
        for (int k = 0; k < 6; k++) begin
            pulse_in(0, 1, 3, 3);
            @(negedge clk);
            n = cyc - cyc0;
            check("R2 low half dual", int'(count[7:0]), (n / 3) % 10);
            check("R6 high half dual ignores events", int'(count[15:8]), n % 5);
            check("R2 low flag", int'(irq_lo), int'((n / 3) >= 10));
            check("R2 high flag", int'(irq_hi), int'(n >= 5));
        end

        // Configuration 1: low timer P=1 M=5, high event counter M=5
        wr(3'd1, 8'd5); wr(3'd2, 8'd5); wr(3'd3, 8'd1);
        wr(3'd0, 8'd1);
        wr(3'd5, 8'd2);
        check("R11 high flag cleared", int'(irq_hi), 0);
        pulse_in(0, 13, 3, 3);
        repeat (4) @(negedge clk);
        n = cyc - cyc0;
        check("R3 high half counts events", int'(count[15:8]), 13 % 6);
        check("R3 low half timer", int'(count[7:0]), (n / 2) % 6);
        check("R3 high flag after wrap", int'(irq_hi), 1);
        pulse_in(2, 1, 2, 6);
        check("R7 high capture byte", int'(capture[15:8]), 1);
        check("R7 low capture byte untouched", int'(capture[7:0]), 0);
        @(negedge clk);
        c = cyc;
        cap_lo_in = 1'b1;
        repeat (2) @(negedge clk);
        cap_lo_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 low capture timing split", int'(capture[7:0]), ((c + 2 - cyc0) / 2) % 6);
        check("R7 high capture byte untouched", int'(capture[15:8]), 1);
        repeat (20) @(negedge clk);
        check("R11 high flag sticky", int'(irq_hi), 1);
        wr(3'd5, 8'd2);
        check("R11 high flag cleared again", int'(irq_hi), 0);

        // Configuration 2: 16-bit timer P=0, match 300
        wr(3'd1, 8'h2C); wr(3'd2, 8'h01); wr(3'd3, 8'd0);
        wr(3'd0, 8'd2);
        wr(3'd5, 8'd3);
        check("R11 both flags cleared", int'({irq_hi, irq_lo}), 0);
        pulse_in(0, 20, 3, 3);
        repeat (100) @(negedge clk);
        n = cyc - cyc0;
        check("R4 sixteen-bit count with carry", int'(count), n % 301);
        check("R6 events ignored in configuration 2", int'(irq_hi), int'(n >= 301));
        @(negedge clk);
        c = cyc;
        cap_lo_in = 1'b1;
        repeat (2) @(negedge clk);
        cap_lo_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 R9 wide capture", int'(capture), (c + 2 - cyc0) % 301);
        repeat (200) @(negedge clk);
        n = cyc - cyc0;
        check("R4 count after full match clear", int'(count), n % 301);
        check("R4 high flag on full match", int'(irq_hi), 1);
        check("R4 low flag stays clear", int'(irq_lo), 0);

        // Configuration 3: 16-bit event counter, narrow pulses
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'd3);
        check("R10 count zero in configuration 3", int'(count), 0);
        wr(3'd5, 8'd3);
        pulse_in(0, 300, 1, 1);
        repeat (5) @(negedge clk);
        check("R5 narrow pulses with carry", int'(count), 300);
        wr(3'd1, 8'd3); wr(3'd2, 8'd0);
        wr(3'd0, 8'd3);
        pulse_in(0, 9, 3, 3);
        repeat (4) @(negedge clk);
        check("R5 wrap at sixteen-bit match", int'(count), 9 % 4);
        check("R5 high flag", int'(irq_hi), 1);
        check("R4 low flag clear in configuration 3", int'(irq_lo), 0);
        pulse_in(2, 1, 2, 6);
        check("R8 high capture input copies both halves", int'(capture), 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule